// File: doc/BRIEF.md
# Atomic Reservation Tracker

This block keeps the reservation state for reserve-load / conditional-store pairs issued by up to four cores, one thread each, that share a single memory bus. It sits on the command path in front of the bus arbiter. Every cycle it looks at one command slot per core. A slot is idle, a reserve-load, a plain store or a conditional-store, and it carries a 32-bit address. The block is the only place where the cores' atomic sequences are ordered against each other.

Each core owns one reservation register. The register holds a valid flag and the address of a 32-byte granule. A reserve-load arms the register as soon as the command is accepted, without waiting for the reload data. When a reserve-load hits in the core's own L1, the core invalidates that line itself, so the block never sends a back-invalidate. In the cycle a conditional-store is presented, the block returns a completion strobe with a pass/fail flag to the issuing core. In the same cycle it tells the arbiter, per core, whether a write may go onto the bus.

Top module: `atomic_resv_tracker`

## Requirements
- R1: Granule comparison ignores address bits 4:0. An address that differs from the reserved one only in bits 4:0 matches. A difference in any bit 31:5 does not match.
- R2: Each core holds one reservation. A reserve-load (op code 1) replaces any earlier reservation of the same core.
- R3: A reserve-load presented in cycle t arms the reservation, so a conditional-store from the same core in cycle t+1 can pass.
- R4: A conditional-store (op code 3) from core i drives sc_resp[i]=1 in the same cycle. sc_pass[i] is 1 only when core i's reservation is valid and its granule matches the store address.
- R5: Any conditional-store clears the issuing core's reservation from the next cycle on, whether it passes or fails.
- R6: bus_wr_en[i] is 1 for a plain store (op code 2) and for a passing conditional-store. It is 0 for a failing conditional-store, for a reserve-load and for idle (op code 0).
- R7: A plain store or a passing conditional-store from core j clears the valid reservation of every other core k≠j whose granule matches. A core's own plain store does not clear its own reservation, and a store to a different granule clears nothing.
- R8: When several cores present conditional-stores to the same granule in one cycle and each of them holds a matching reservation, only the lowest-numbered core passes. The others fail.
- R9: Synchronous active-low reset clears every reservation, so no conditional-store passes until a new reserve-load is made.
- R10: When a core presents a reserve-load in the same cycle that another core stores to the same granule, the reserve-load takes effect. The store is ordered before it and the reservation ends up armed.
- R11: All conditional-stores in a cycle are judged against the reservation state at the start of that cycle. A plain store to the same granule in the same cycle does not make them fail.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_op | input | 2*NUM_CORES | Per-core op code: 0 idle, 1 reserve-load, 2 store, 3 conditional-store; core i in bits [2i+1:2i] |
| cmd_addr | input | 32*NUM_CORES | Per-core byte address; core i in bits [32i+31:32i] |
| sc_resp | output | NUM_CORES | Completion strobe for a conditional-store, per core |
| sc_pass | output | NUM_CORES | Pass flag qualifying sc_resp |
| bus_wr_en | output | NUM_CORES | The core's write may be forwarded to the bus |

## Verification
The bench targets these corner cases. A store-conditional whose address differs only in the low five bits must pass; a design that compares too many bits would fail it. A new reserve-load must replace the old granule; a design that keeps the first reservation would pass a store to the stale address. Two simultaneous conditional-stores to one granule must let exactly one pass; a wrong priority or a missing cross-check would pass both or the wrong one. Same-cycle reserve-load against another core's store, and conditional-store against a plain store, pin down the intra-cycle ordering that a design with the wrong update priority would get backwards. A long pseudo-random run over three granules and all four cores compares every output each cycle with an arithmetic model built from the requirements.

// File: rtl/resv_pkg.sv
// Package: shared op codes for the reservation tracker.
// Assumes a 2-bit op field per core.
package resv_pkg;
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_LRSV  = 2'd1,
        OP_STORE = 2'd2,
        OP_CSTO  = 2'd3
    } resv_op_e;
endpackage

// File: rtl/resv_slot.sv
// Module: one reservation register (valid flag + granule address).
// Assumes set and clear come from the top; set has priority over clear.
module resv_slot #(
    parameter int GRAN_W = 27
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_i,
    input  logic [GRAN_W-1:0] set_gran_i,
    input  logic              clr_i,
    output logic              valid_o,
    output logic [GRAN_W-1:0] gran_o
);
    // Hold, arm or drop the reservation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            gran_o  <= '0;
        end else if (set_i) begin
            valid_o <= 1'b1;
            gran_o  <= set_gran_i;
        end else if (clr_i) begin
            valid_o <= 1'b0;
        end
    end
endmodule

// File: rtl/resv_sc_prio.sv
// Module: resolves same-granule conditional-store collisions.
// A candidate passes unless a lower-numbered candidate targets the same granule.
// Assumes candidates are already qualified by their own reservation.
module resv_sc_prio #(
    parameter int NUM_CORES = 4,
    parameter int GRAN_W    = 27
) (
    input  logic [NUM_CORES-1:0]        cand_i,
    input  logic [NUM_CORES*GRAN_W-1:0] gran_i,
    output logic [NUM_CORES-1:0]        pass_o
);
    // Mask each candidate with any earlier same-granule candidate.
    always_comb begin
        for (int i = 0; i < NUM_CORES; i++) begin
            pass_o[i] = cand_i[i];
            for (int j = 0; j < i; j++) begin
                if (cand_i[j] && gran_i[j*GRAN_W +: GRAN_W] == gran_i[i*GRAN_W +: GRAN_W])
                    pass_o[i] = 1'b0;
            end
        end
    end
endmodule

// File: rtl/atomic_resv_tracker.sv
// Module: reservation tracker for reserve-load / conditional-store pairs.
// Watches one command slot per core per cycle and judges conditional-stores
// against the reservation state at the start of the cycle. Outputs are
// combinational in the command cycle; the reservations update at the next edge.
// Assumes each presented command is accepted in that cycle.
module atomic_resv_tracker #(
    parameter int NUM_CORES = 4,
    parameter int ADDR_W    = 32,
    parameter int GRAN_LSB  = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [2*NUM_CORES-1:0]    cmd_op,
    input  logic [ADDR_W*NUM_CORES-1:0] cmd_addr,
    output logic [NUM_CORES-1:0]      sc_resp,
    output logic [NUM_CORES-1:0]      sc_pass,
    output logic [NUM_CORES-1:0]      bus_wr_en
);
    import resv_pkg::*;

    localparam int GRAN_W = ADDR_W - GRAN_LSB;

    logic [NUM_CORES-1:0]        is_lrsv, is_store, is_csto;
    logic [NUM_CORES*GRAN_W-1:0] cmd_gran;
    logic [NUM_CORES-1:0]        slot_valid;
    logic [NUM_CORES*GRAN_W-1:0] slot_gran;
    logic [NUM_CORES-1:0]        sc_cand;
    logic [NUM_CORES-1:0]        wr_commit;
    logic [NUM_CORES-1:0]        snoop_kill;
    logic [NUM_CORES-1:0]        slot_clr;

    generate
        for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
            // Decode the op code and cut the granule out of the address.
            always_comb begin
                is_lrsv[c]  = cmd_op[2*c +: 2] == OP_LRSV;
                is_store[c] = cmd_op[2*c +: 2] == OP_STORE;
                is_csto[c]  = cmd_op[2*c +: 2] == OP_CSTO;
                cmd_gran[c*GRAN_W +: GRAN_W] = cmd_addr[c*ADDR_W + GRAN_LSB +: GRAN_W];
            end

            // Qualify a conditional-store against the core's own reservation.
            always_comb begin
                sc_cand[c] = is_csto[c] && slot_valid[c] &&
                             (slot_gran[c*GRAN_W +: GRAN_W] == cmd_gran[c*GRAN_W +: GRAN_W]);
            end

            // Detect a committed write by another core to this reservation's granule.
            always_comb begin
                snoop_kill[c] = 1'b0;
                for (int j = 0; j < NUM_CORES; j++) begin
                    if (j != c && wr_commit[j] &&
                        cmd_gran[j*GRAN_W +: GRAN_W] == slot_gran[c*GRAN_W +: GRAN_W])
                        snoop_kill[c] = 1'b1;
                end
                slot_clr[c] = is_csto[c] || (slot_valid[c] && snoop_kill[c]);
            end

            resv_slot #(.GRAN_W(GRAN_W)) u_slot (
                .clk        (clk),
                .rst_n      (rst_n),
                .set_i      (is_lrsv[c]),
                .set_gran_i (cmd_gran[c*GRAN_W +: GRAN_W]),
                .clr_i      (slot_clr[c]),
                .valid_o    (slot_valid[c]),
                .gran_o     (slot_gran[c*GRAN_W +: GRAN_W])
            );
        end
    endgenerate

    resv_sc_prio #(.NUM_CORES(NUM_CORES), .GRAN_W(GRAN_W)) u_prio (
        .cand_i (sc_cand),
        .gran_i (cmd_gran),
        .pass_o (sc_pass)
    );

    // Drive responses and the bus write enables.
    always_comb begin
        wr_commit = is_store | sc_pass;
        sc_resp   = is_csto;
        bus_wr_en = wr_commit;
    end
endmodule

// File: rtl/atomic_resv_tracker_chk.sv
// Checker: port-level properties of the reservation tracker, bound to the top.
module atomic_resv_tracker_chk #(
    parameter int NUM_CORES = 4,
    parameter int ADDR_W    = 32,
    parameter int GRAN_LSB  = 5
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [2*NUM_CORES-1:0]      cmd_op,
    input logic [ADDR_W*NUM_CORES-1:0] cmd_addr,
    input logic [NUM_CORES-1:0]        sc_resp,
    input logic [NUM_CORES-1:0]        sc_pass,
    input logic [NUM_CORES-1:0]        bus_wr_en
);
    localparam int GRAN_W = ADDR_W - GRAN_LSB;

    generate
        for (genvar i = 0; i < NUM_CORES; i++) begin : g_chk
            // R4: a pass flag only comes with a completion strobe
            a_r4_pass_with_resp: assert property (@(posedge clk) disable iff (!rst_n)
                sc_pass[i] |-> sc_resp[i]);
            // R6: a failing conditional-store never reaches the bus
            a_r6_fail_blocked: assert property (@(posedge clk) disable iff (!rst_n)
                (sc_resp[i] && !sc_pass[i]) |-> !bus_wr_en[i]);
            // R5: two conditional-stores back to back: the second fails
            a_r5_sc_clears: assert property (@(posedge clk) disable iff (!rst_n)
                (sc_resp[i] && $past(sc_resp[i])) |-> !sc_pass[i]);
            // R9: first cycle out of reset has no reservation
            a_r9_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
                $past(!rst_n) |-> !sc_pass[i]);
            for (genvar j = i + 1; j < NUM_CORES; j++) begin : g_pair
                // R8: two passes in one cycle never share a granule
                a_r8_one_winner: assert property (@(posedge clk) disable iff (!rst_n)
                    (sc_pass[i] && sc_pass[j]) |->
                    (cmd_addr[i*ADDR_W + GRAN_LSB +: GRAN_W] != cmd_addr[j*ADDR_W + GRAN_LSB +: GRAN_W]));
            end
        end
    endgenerate
endmodule

bind atomic_resv_tracker atomic_resv_tracker_chk #(
    .NUM_CORES (NUM_CORES),
    .ADDR_W    (ADDR_W),
    .GRAN_LSB  (GRAN_LSB)
) u_chk (.*);

// File: tb/atomic_resv_tracker_tb.sv
// Bench: directed corner cases plus a pseudo-random sweep against an arithmetic model.
module atomic_resv_tracker_tb;
    localparam int N = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2*N-1:0]  cmd_op = '0;
    logic [32*N-1:0] cmd_addr = '0;
    logic [N-1:0]  sc_resp, sc_pass, bus_wr_en;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // model state
    bit        m_v [N];
    bit [26:0] m_g [N];

    always #2 clk = ~clk;

    atomic_resv_tracker u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
        .sc_resp(sc_resp), .sc_pass(sc_pass), .bus_wr_en(bus_wr_en)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Present one cycle of commands, compare outputs with the model, advance the model.
    task automatic step(input logic [2*N-1:0] ops, input logic [32*N-1:0] adrs, input string req);
        bit [N-1:0] e_resp, e_pass, e_wr, cand, kill;
        bit [26:0]  g [N];
        @(negedge clk);
        cmd_op   = ops;
        cmd_addr = adrs;
        #1;
        for (int i = 0; i < N; i++) g[i] = adrs[32*i+5 +: 27];
        for (int i = 0; i < N; i++)
            cand[i] = ops[2*i +: 2] == 2'd3 && m_v[i] && m_g[i] == g[i];
        for (int i = 0; i < N; i++) begin
            e_pass[i] = cand[i];
            for (int j = 0; j < i; j++) if (cand[j] && g[j] == g[i]) e_pass[i] = 1'b0;
            e_resp[i] = ops[2*i +: 2] == 2'd3;
        end
        for (int i = 0; i < N; i++) e_wr[i] = ops[2*i +: 2] == 2'd2 || e_pass[i];
        check(sc_resp == e_resp, {req, " resp"}, sc_resp, e_resp);
        check(sc_pass == e_pass, {req, " pass"}, sc_pass, e_pass);
        check(bus_wr_en == e_wr, {req, " bus"}, bus_wr_en, e_wr);
        for (int k = 0; k < N; k++) begin
            kill[k] = 1'b0;
            for (int j = 0; j < N; j++) if (j != k && e_wr[j] && g[j] == m_g[k]) kill[k] = 1'b1;
        end
        for (int k = 0; k < N; k++) begin
            if (ops[2*k +: 2] == 2'd1) begin m_v[k] = 1'b1; m_g[k] = g[k]; end
            else if (ops[2*k +: 2] == 2'd3 || kill[k]) m_v[k] = 1'b0;
        end
    endtask

    // Build a one-core command vector.
    function automatic logic [2*N-1:0] op1(input int c, input logic [1:0] op);
        logic [2*N-1:0] r = '0;
        r[2*c +: 2] = op;
        return r;
    endfunction
    function automatic logic [32*N-1:0] ad1(input int c, input logic [31:0] a);
        logic [32*N-1:0] r = '0;
        r[32*c +: 32] = a;
        return r;
    endfunction

    // Expect a single conditional-store outcome at the ports.
    task automatic expect_sc(input int c, input logic [31:0] a, input bit exp, input string req);
        step(op1(c, 2'd3), ad1(c, a), req);
        check(sc_pass[c] == exp, req, sc_pass[c], exp);
    endtask

    initial begin
        #200000;
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("%0d/%0d checks passed", n_checks + 1 - n_fail, n_checks + 1);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) begin m_v[i] = 0; m_g[i] = '0; end
        repeat (3) @(negedge clk);
        #1;
        check(sc_resp == 0 && sc_pass == 0 && bus_wr_en == 0, "R9 reset outputs", sc_pass, 0);
        @(negedge clk);
        rst_n = 1'b1;
        // R9: no reservation after reset
        expect_sc(0, 32'h0, 1'b0, "R9");
        // R3, R1: arm then pass with different low bits
        step(op1(0, 2'd1), ad1(0, 32'h100), "R3 lr");
        expect_sc(0, 32'h11C, 1'b1, "R1 R3");
        // R5: reservation consumed
        expect_sc(0, 32'h100, 1'b0, "R5");
        // R1: bit 5 differs -> no match; R5 fail also clears
        step(op1(0, 2'd1), ad1(0, 32'h100), "R1 lr");
        expect_sc(0, 32'h120, 1'b0, "R1");
        expect_sc(0, 32'h100, 1'b0, "R5 fail clears");
        // R2: replacement
        step(op1(1, 2'd1), ad1(1, 32'h100), "R2 lr a");
        step(op1(1, 2'd1), ad1(1, 32'h200), "R2 lr b");
        expect_sc(1, 32'h100, 1'b0, "R2 old");
        step(op1(1, 2'd1), ad1(1, 32'h200), "R2 lr b2");
        expect_sc(1, 32'h204, 1'b1, "R2 new");
        // R7: other-core store kills, own store keeps, other granule keeps
        step(op1(0, 2'd1), ad1(0, 32'h100), "R7 lr");
        step(op1(1, 2'd2), ad1(1, 32'h104), "R7 st");
        expect_sc(0, 32'h100, 1'b0, "R7 kill");
        step(op1(0, 2'd1), ad1(0, 32'h100), "R7 lr2");
        step(op1(0, 2'd2), ad1(0, 32'h100), "R7 own st");
        step(op1(1, 2'd2), ad1(1, 32'h140), "R7 far st");
        expect_sc(0, 32'h100, 1'b1, "R7 keep");
        // R7: passing SC from another core kills
        step(op1(0, 2'd1) | op1(1, 2'd1), ad1(0, 32'h300) | ad1(1, 32'h300), "R7 lr pair");
        expect_sc(1, 32'h300, 1'b1, "R7 sc win");
        expect_sc(0, 32'h300, 1'b0, "R7 sc kill");
        // R8: same-cycle conditional-stores, lowest index wins
        step(op1(1, 2'd1) | op1(2, 2'd1), ad1(1, 32'h400) | ad1(2, 32'h408), "R8 lr");
        step(op1(1, 2'd3) | op1(2, 2'd3), ad1(1, 32'h400) | ad1(2, 32'h400), "R8 sc");
        check(sc_pass[2:1] == 2'b01, "R8 winner", sc_pass[2:1], 2'b01);
        // R10: LR beats a same-cycle foreign store
        step(op1(0, 2'd1) | op1(3, 2'd2), ad1(0, 32'h500) | ad1(3, 32'h500), "R10");
        expect_sc(0, 32'h500, 1'b1, "R10");
        // R11: SC and foreign store in the same cycle -> SC still passes
        step(op1(0, 2'd1), ad1(0, 32'h600), "R11 lr");
        step(op1(0, 2'd3) | op1(2, 2'd2), ad1(0, 32'h600) | ad1(2, 32'h600), "R11");
        check(sc_pass[0] == 1'b1 && bus_wr_en[2] == 1'b1, "R11 both", {sc_pass[0], bus_wr_en[2]}, 2'b11);
        // R6: reserve-load and idle never write
        step(op1(2, 2'd1), ad1(2, 32'h700), "R6 lr");
        check(bus_wr_en == 0, "R6 no write", bus_wr_en, 0);
        // Sweep: all cores, three granules, random low bits
        for (int t = 0; t < 3000; t++) begin
            logic [2*N-1:0]  o;
            logic [32*N-1:0] a;
            for (int c = 0; c < N; c++) begin
                o[2*c +: 2]  = 2'($urandom_range(0, 3));
                a[32*c +: 32] = (32'($urandom_range(0, 2)) << 5) | 32'($urandom_range(0, 31));
            end
            step(o, a, "R4 R7 R8 sweep");
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule